// File: doc/BRIEF.md
# I2S Microphone Serial Transmitter

This block is the serial output stage of a digital microphone that shares one I2S data wire with a second microphone. The bus master drives the bit clock and word select. The block is a slave to both and has no clock of its own. It takes 24-bit two's complement samples from an internal source through a small stream port. It waits for the half-frame chosen by its channel strap and sends the held sample MSB first. It lets go of the wire as soon as the last bit has been sent.

All state changes on the falling edge of the bit clock, so a receiver can sample on the rising edge. Word select is sampled on each falling edge, and a change in its level marks a new half-frame. The MSB goes out at the first falling edge after word select changes to the block's own channel. That places the MSB one bit time after the word-select change, as standard I2S requires. The master is expected to give 32 bit clocks per channel, which is 64 per stereo frame. The 24 data bits fill the start of the slot, and the rest of the slot is left undriven. The data bit and the output enable leave the block as two separate pins. The pad, or a bench, combines them with a pull-down on the shared wire.

The sample port follows valid/ready rules. It holds one word. `s_ready` is high while that holder is empty. A word is taken on the falling edge at which both `s_valid` and `s_ready` are high. The source must keep `s_valid` and `s_data` steady until that edge. At the start of its own slot the block moves the held word into the shifter and frees the holder. If the holder is empty at that point, the block sends a word of zeros.

Top module: `i2s_mic_tx`

## Requirements
- R1: While `rst_n` is low, which resets asynchronously, `sd_oe` is 0 and `s_ready` is 1. This holds also when reset arrives in the middle of a word.
- R2: The channel strap sets the slot: `lr_sel`=0 picks the half-frame with `ws` low, and `lr_sel`=1 picks the half-frame with `ws` high. The block starts driving at the first falling edge at which the sampled `ws` has changed to the block's own level. A receiver therefore reads the MSB on the second rising edge after the `ws` change.
- R3: A word is 24 bits, MSB first, and `sd_dat` changes only on falling edges. `sd_oe` stays high for exactly 24 bit periods per word.
- R4: After the LSB, `sd_oe` is 0 for the rest of the slot. It stays 0 throughout the half-frame of the other channel.
- R5: If `ws` leaves the block's own level before the word is complete, `sd_oe` goes to 0 at the next falling edge.
- R6: `s_ready` is 1 exactly while the one-word holder is empty. A word is accepted when `s_valid` and `s_ready` are both high at a falling edge, and `s_ready` is 0 after that edge. A word offered while `s_ready` is 0 is not taken. The holder is freed at the start of the next own slot.
- R7: If no word is held when the own slot starts, the block still drives all 24 bit periods, and every bit is 0.
- R8: Two instances strapped to opposite channels can share one wire with a pull-down. Their output enables are never high at the same time.
- R9: After reset is released, the first falling edge only records `ws`. No slot starts there, even if `ws` already equals the block's own level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Bit clock from the bus master; logic acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Word select from the bus master |
| lr_sel | input | 1 | Channel strap: 0 sends in the low half-frame, 1 in the high half-frame |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Holder empty, sample can be taken |
| s_data | input | 24 | Two's complement sample |
| sd_dat | output | 1 | Serial data bit, meaningful while sd_oe is 1 |
| sd_oe | output | 1 | Drive enable for the shared data wire |

## Verification
The bench runs two instances on one modelled wire with a pull-down. Through a series of frames it checks that each word comes back bit for bit and that no bit period is driven by both instances. A design one bit early or late corrupts every word. A design that pads the tail of the slot or overruns the LSB is seen as an enable count other than 24. A design that runs its enable into the peer's half shows up as contention.

Directed tests cover the following cases:
- an empty holder, which must still yield a driven word of zeros;
- a full holder, which must refuse a second word and send the first;
- a word-select change in the middle of a word, which must cut the output off at once;
- a reset in the middle of a word;
- the first edge after reset. A design that takes the reset value of its word-select history as real would start a false slot there.

// File: rtl/i2s_mic_tx_pkg.sv
package i2s_mic_tx_pkg;
  localparam int unsigned SAMPLE_BITS = 24;

  typedef enum logic {
    CHAN_LOW_HALF  = 1'b0,
    CHAN_HIGH_HALF = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_ws_tracker.sv
module i2s_ws_tracker
  import i2s_mic_tx_pkg::*;
(
  input  logic sck,
  input  logic rst_n,
  input  logic ws,
  input  chan_e chan,
  output logic slot_start,
  output logic in_slot
);
  logic ws_prev;
  logic primed;

  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      primed  <= 1'b0;
    end else begin
      ws_prev <= ws;
      primed  <= 1'b1;
    end
  end

  assign in_slot    = (ws == logic'(chan));
  assign slot_start = primed && (ws != ws_prev) && in_slot;
endmodule

// File: rtl/i2s_word_holder.sv
module i2s_word_holder #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              take,
  output logic [DATA_W-1:0] word_out
);
  logic              full;
  logic [DATA_W-1:0] held;
  logic              accept;

  assign s_ready = !full;
  assign accept  = s_valid && !full;

  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else begin
      if (accept) held <= s_data;
      full <= (full && !take) || accept;
    end
  end

  assign word_out = full ? held : '0;
endmodule

// File: rtl/i2s_bit_shifter.sv
module i2s_bit_shifter #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              keep,
  output logic              sd_dat,
  output logic              sd_oe
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx;
  logic              active;

  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
      active  <= 1'b0;
    end else if (load) begin
      shreg   <= load_word;
      bit_idx <= '0;
      active  <= 1'b1;
    end else if (active) begin
      if (!keep || bit_idx == LAST_BIT) begin
        active <= 1'b0;
      end else begin
        shreg   <= {shreg[DATA_W-2:0], 1'b0};
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign sd_oe  = active;
  assign sd_dat = active & shreg[DATA_W-1];
endmodule

// File: rtl/i2s_mic_tx.sv
module i2s_mic_tx
  import i2s_mic_tx_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_BITS
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              ws,
  input  logic              lr_sel,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              sd_dat,
  output logic              sd_oe
);
  logic              slot_start;
  logic              in_slot;
  logic [DATA_W-1:0] next_word;
  chan_e             chan;

  assign chan = chan_e'(lr_sel);

  i2s_ws_tracker u_ws (
    .sck        (sck),
    .rst_n      (rst_n),
    .ws         (ws),
    .chan       (chan),
    .slot_start (slot_start),
    .in_slot    (in_slot)
  );

  i2s_word_holder #(.DATA_W(DATA_W)) u_hold (
    .sck      (sck),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_data   (s_data),
    .take     (slot_start),
    .word_out (next_word)
  );

  i2s_bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .sck       (sck),
    .rst_n     (rst_n),
    .load      (slot_start),
    .load_word (next_word),
    .keep      (in_slot),
    .sd_dat    (sd_dat),
    .sd_oe     (sd_oe)
  );
endmodule

// File: rtl/i2s_mic_tx_chk.sv
module i2s_mic_tx_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic              sck,
  input logic              rst_n,
  input logic              ws,
  input logic              lr_sel,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic              sd_dat,
  input logic              sd_oe
);
  logic [15:0] run_len;

  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= sd_oe ? run_len + 16'd1 : 16'd0;
  end

  // R1: quiet and empty during reset
  always_ff @(posedge sck) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!sd_oe && s_ready);
    end
  end

  a_r2_slot_start: assert property (@(negedge sck) disable iff (!rst_n)
    ($past(rst_n) && ws != $past(ws) && ws == lr_sel) |=> sd_oe);

  a_r3_word_length: assert property (@(negedge sck) disable iff (!rst_n)
    sd_oe |-> (run_len < 16'(DATA_W)));

  a_r5_leave_slot: assert property (@(negedge sck) disable iff (!rst_n)
    (ws != lr_sel) |=> !sd_oe);

  a_r6_hold_full: assert property (@(negedge sck) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  wire unused_ok = &{1'b0, s_data, sd_dat};
endmodule

bind i2s_mic_tx i2s_mic_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .sck     (sck),
  .rst_n   (rst_n),
  .ws      (ws),
  .lr_sel  (lr_sel),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_data  (s_data),
  .sd_dat  (sd_dat),
  .sd_oe   (sd_oe)
);

// File: tb/i2s_mic_tx_bench.sv
module i2s_mic_tx_bench;
  logic sck = 1'b0;
  logic rst_n = 1'b0;
  logic ws = 1'b1;
  logic vl = 1'b0, vr = 1'b0;
  logic [23:0] dl = '0, dr = '0;
  logic rl, rr, sdl, sdr, oel, oer;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 sck = ~sck;

  i2s_mic_tx u_i2s_mic_tx (
    .sck(sck), .rst_n(rst_n), .ws(ws), .lr_sel(1'b0),
    .s_valid(vl), .s_ready(rl), .s_data(dl), .sd_dat(sdl), .sd_oe(oel)
  );

  i2s_mic_tx u_i2s_mic_tx_peer (
    .sck(sck), .rst_n(rst_n), .ws(ws), .lr_sel(1'b1),
    .s_valid(vr), .s_ready(rr), .s_data(dr), .sd_dat(sdr), .sd_oe(oer)
  );

  wire bus = oel ? sdl : (oer ? sdr : 1'b0);

  localparam logic [47:0] VEC [8] = '{
    {24'h800000, 24'h7FFFFF}, {24'hFFFFFF, 24'h000001},
    {24'hA5A5A5, 24'h5A5A5A}, {24'h000000, 24'hFFFFFE},
    {24'h123456, 24'hABCDEF}, {24'h800001, 24'h7FFFFE},
    {24'hC00003, 24'h3FFFFC}, {24'h0F0F0F, 24'hF0F0F0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge sck);
    #1;
  endtask

  task automatic push(input bit right, input logic [23:0] d);
    step();
    if (right) begin vr = 1'b1; dr = d; end else begin vl = 1'b1; dl = d; end
    step();
    vr = 1'b0;
    vl = 1'b0;
  endtask

  int clash_total = 0;

  task automatic run_half(input logic w, input bit do_push, input logic [23:0] pw,
                          output logic [23:0] got, output int own, output int stray);
    got = '0; own = 0; stray = 0;
    for (int k = 0; k < 32; k++) begin
      logic o_own, o_oth;
      step();
      o_own = w ? oer : oel;
      o_oth = w ? oel : oer;
      if (oel && oer) clash_total++;
      if (k >= 1 && k <= 24) begin
        got = {got[22:0], bus};
        if (o_own) own++;
      end else if (o_own) stray++;
      if (o_oth) stray++;
      if (k == 0) ws = w;
      if (k == 2 && do_push) begin
        if (w) begin vr = 1'b1; dr = pw; end else begin vl = 1'b1; dl = pw; end
      end
      if (k == 3) begin vl = 1'b0; vr = 1'b0; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [23:0] got;
    int own, stray, bad_oe;
    // R1: reset state
    repeat (3) step();
    check(!oel && !oer, "R1 oe in reset", {oel, oer}, 0);
    check(rl && rr, "R1 ready in reset", {rl, rr}, 2'b11);
    rst_n = 1'b1;
    // R9: ws already high equals peer channel, no false start
    bad_oe = 0;
    for (int i = 0; i < 30; i++) begin step(); if (oer || oel) bad_oe++; end
    check(bad_oe == 0, "R9 no start on first edge", bad_oe, 0);

    push(1'b0, VEC[0][47:24]);
    push(1'b1, VEC[0][23:0]);
    clash_total = 0;
    for (int i = 0; i < 8; i++) begin
      logic [47:0] nx;
      nx = (i < 7) ? VEC[i+1] : 48'h0;
      run_half(1'b0, i < 7, nx[47:24], got, own, stray);
      check(got == VEC[i][47:24], "R2 R3 left word", got, VEC[i][47:24]);
      check(own == 24 && stray == 0, "R3 R4 left enable", {own[15:0], stray[15:0]}, {16'd24, 16'd0});
      run_half(1'b1, i < 7, nx[23:0], got, own, stray);
      check(got == VEC[i][23:0], "R2 R3 right word", got, VEC[i][23:0]);
      check(own == 24 && stray == 0, "R3 R4 right enable", {own[15:0], stray[15:0]}, {16'd24, 16'd0});
      check(clash_total == 0, "R8 no contention", clash_total, 0);
    end

    // R7: empty holder, zero word still driven
    run_half(1'b0, 1'b0, 24'h0, got, own, stray);
    check(got == 24'h0 && own == 24, "R7 underrun left", {got, own[7:0]}, {24'h0, 8'd24});
    run_half(1'b1, 1'b0, 24'h0, got, own, stray);
    check(own == 24 && stray == 0, "R7 underrun right", own, 24);

    // R6: back-pressure with a full holder
    push(1'b0, 24'h3C3C3C);
    check(!rl, "R6 ready low when full", rl, 0);
    step(); vl = 1'b1; dl = 24'hC3C3C3;
    repeat (3) step();
    vl = 1'b0;
    run_half(1'b0, 1'b0, 24'h0, got, own, stray);
    check(got == 24'h3C3C3C, "R6 refused word not taken", got, 24'h3C3C3C);
    check(rl, "R6 ready after slot start", rl, 1);
    run_half(1'b1, 1'b0, 24'h0, got, own, stray);

    // R5: ws leaves early, output released next falling edge
    push(1'b0, 24'hFFFFFF);
    step(); ws = 1'b0;
    repeat (10) step();
    check(oel, "R5 driving mid word", oel, 1);
    ws = 1'b1;
    step();
    check(!oel, "R5 released after early ws", oel, 0);
    check(!(oel && oer), "R8 no clash at early switch", {oel, oer}, 2'b01);
    repeat (31) step();

    // R1: reset mid word releases at once
    push(1'b0, 24'hFFFFFF);
    step(); ws = 1'b0;
    repeat (6) step();
    rst_n = 1'b0;
    #1;
    check(!oel && rl, "R1 reset mid word", {oel, rl}, 2'b01);
    repeat (2) step();
    rst_n = 1'b1;
    repeat (4) step();
    finish_run();
  end
endmodule